// File: doc/BRIEF.md
# Synchronous Burst Cache Data SRAM

This block models the data store of a secondary cache: a synchronous SRAM one 64-bit word wide, split into eight byte lanes, with a registered address and a two-bit burst counter. A cycle starts when either of two active-low address strobes is sampled low. One strobe belongs to the processor and the other to the cache controller. After that, further cycles within the same four-word block are reached by pulsing a burst-advance input instead of presenting a new address. The walk through the block follows either an XOR (interleaved) order or a wrap-around linear order. An order-select input picks between them and is sampled on every edge, so the order can change in the middle of a burst.

Every input is captured on the rising clock edge except the output enable, which gates the read port combinationally. There is no tri-state. Read data leaves on a dedicated bus with a valid flag, and the bus is forced to zero whenever the flag is low. A read access loads a pipeline register, so the word appears in the cycle after the edge that captured its address. Writes are masked per byte lane by eight active-low enables.

The two strobes differ in how they treat chip select. A controller strobe with chip select inactive puts the device into the deselected state. A processor strobe with chip select inactive is dropped completely. A processor strobe always starts a read, and it wins when both strobes are low together.

Top module: `burst_cache_sram`

## Requirements
- R1: A read access loads the addressed word into the output register at the capturing edge, so the word appears on `rd_data` with `rd_valid` high during the following cycle, provided `oe_n` is low.
- R2: `cpu_stb_n` low with `cs_n` low starts a burst at `addr` whose first access is a read, whatever `bwe_n` holds, and it takes precedence when `ctl_stb_n` is also low. Write enables presented on the next edge write the same word.
- R3: `cpu_stb_n` low with `cs_n` high is ignored entirely: the select state, the burst count and the array stay unchanged, and no read is produced.
- R4: `ctl_stb_n` low with `cpu_stb_n` high and `cs_n` low starts a burst at `addr`. That access writes if any `bwe_n` bit is low and reads otherwise.
- R5: `ctl_stb_n` low with `cpu_stb_n` high and `cs_n` high deselects the device. While deselected, with no strobe, `adv_n` and `bwe_n` have no effect: nothing is written and no read appears.
- R6: In a selected cycle with both strobes high, `adv_n` low advances the two-bit burst count before that cycle's access. The access goes to the current burst address, and it writes if any `bwe_n` bit is low and reads otherwise.
- R7: With `order_sel` high (interleaved), address bits [1:0] equal the start bits XOR the count, and the upper bits keep the start value. After four steps the count wraps to the start word.
- R8: With `order_sel` low (linear), address bits [1:0] equal the start bits plus the count, modulo 4. The order is taken from `order_sel` on each edge, including partway through a burst.
- R9: `bwe_n[i]` low writes `wr_data[8*i+7:8*i]` into lane i. Lanes whose enable is high keep their old contents.
- R10: `oe_n` high forces `rd_valid` low and `rd_data` to zero at once, with no clock edge. Lowering it again restores a pending read word.
- R11: After reset the device is deselected, the count is zero and no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address sampled by a strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Cache controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_n | input | 1 | Chip select, active low |
| bwe_n | input | LANES | Per-lane write enables, active low |
| order_sel | input | 1 | 1 = interleaved burst order, 0 = linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid flag |

## Verification
The properties assume that every input except `oe_n` is stable around the rising edge. They also assume that a pending read belongs only to the access made on the previous edge. The bench meets these conditions by changing all synchronous inputs one nanosecond after an edge. It moves `oe_n` only between edges, where the output gate acts alone. The bench writes every word it later reads back. Because of that, array contents are never unknown when compared, and the no-write properties can be confirmed through later reads.

// File: rtl/burst_cache_pkg.sv
package burst_cache_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Low address bits for a given start point and step count.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count,
    input logic               linear
  );
    logic [BURST_W-1:0] res;
    if (linear) res = start + count;
    else        res = start ^ count;
    return res;
  endfunction

endpackage

// File: rtl/burst_cache_ctr.sv
module burst_cache_ctr
  import burst_cache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               linear,
  input  logic [BURST_W-1:0] start_low,
  output logic [BURST_W-1:0] cnt_q,
  output logic [BURST_W-1:0] acc_low
);

  logic [BURST_W-1:0] base_low_q;
  logic [BURST_W-1:0] cnt_eff;

  always_comb begin
    cnt_eff = step ? cnt_q + BURST_W'(1) : cnt_q;
    acc_low = load ? start_low : burst_low(base_low_q, cnt_eff, linear);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_low_q <= '0;
      cnt_q      <= '0;
    end else if (load) begin
      base_low_q <= start_low;
      cnt_q      <= '0;
    end else if (step) begin
      cnt_q      <= cnt_eff;
    end
  end

endmodule

// File: rtl/burst_cache_ctrl.sv
module burst_cache_ctrl
  import burst_cache_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] bwe_n,
  output logic             sel_q,
  output logic             load,
  output logic             step,
  output logic             cpu_ign,
  output logic             ctl_desel,
  output acc_kind_e        acc_kind
);

  logic cpu_go, ctl_go, cont, any_we, sel_d;

  always_comb begin
    any_we    = ~&bwe_n;
    cpu_go    = !cpu_stb_n && !cs_n;
    cpu_ign   = !cpu_stb_n &&  cs_n;
    ctl_go    =  cpu_stb_n && !ctl_stb_n && !cs_n;
    ctl_desel =  cpu_stb_n && !ctl_stb_n &&  cs_n;
    cont      =  cpu_stb_n &&  ctl_stb_n && sel_q;
    load      = cpu_go || ctl_go;
    step      = cont && !adv_n;

    if (cpu_go)                 acc_kind = ACC_READ;
    else if (ctl_go || cont)    acc_kind = any_we ? ACC_WRITE : ACC_READ;
    else                        acc_kind = ACC_NONE;

    if (load)           sel_d = 1'b1;
    else if (ctl_desel) sel_d = 1'b0;
    else                sel_d = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/burst_cache_lane.sv
module burst_cache_lane #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[acc_addr] <= wdata;
  end

  assign rdata = mem[acc_addr];

endmodule

// File: rtl/burst_cache_sram.sv
module burst_cache_sram
  import burst_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    adv_n,
  input  logic                    cs_n,
  input  logic [LANES-1:0]        bwe_n,
  input  logic                    order_sel,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  // Named internal events, observed by the bound checker.
  logic               sel_q, load, step, cpu_ign, ctl_desel;
  acc_kind_e          acc_kind;
  logic [BURST_W-1:0] cnt_q, acc_low;
  logic [HI_W-1:0]    base_hi_q;
  logic [ADDR_W-1:0]  acc_addr;
  logic [LANES-1:0]   lane_we;
  logic [DATA_W-1:0]  arr_rdata, rdata_q;
  logic               rd_pend_q;

  burst_cache_ctrl #(.LANES(LANES)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .cs_n      (cs_n),
    .adv_n     (adv_n),
    .bwe_n     (bwe_n),
    .sel_q     (sel_q),
    .load      (load),
    .step      (step),
    .cpu_ign   (cpu_ign),
    .ctl_desel (ctl_desel),
    .acc_kind  (acc_kind)
  );

  burst_cache_ctr ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .linear    (!order_sel),
    .start_low (addr[BURST_W-1:0]),
    .cnt_q     (cnt_q),
    .acc_low   (acc_low)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    base_hi_q <= '0;
    else if (load) base_hi_q <= addr[ADDR_W-1:BURST_W];
  end

  assign acc_addr = {(load ? addr[ADDR_W-1:BURST_W] : base_hi_q), acc_low};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = (acc_kind == ACC_WRITE) && !bwe_n[i];

    burst_cache_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
      .clk      (clk),
      .we       (lane_we[i]),
      .acc_addr (acc_addr),
      .wdata    (wr_data[i*LANE_W +: LANE_W]),
      .rdata    (arr_rdata[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rd_pend_q <= (acc_kind == ACC_READ);
      if (acc_kind == ACC_READ) rdata_q <= arr_rdata;
    end
  end

  assign rd_valid = rd_pend_q && !oe_n;
  assign rd_data  = rd_valid ? rdata_q : '0;

endmodule

// File: rtl/burst_cache_chk.sv
module burst_cache_chk #(
  parameter int LANES  = 8,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stb_n,
  input logic              ctl_stb_n,
  input logic              cs_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic [LANES-1:0]  bwe_n,
  input logic              sel_q,
  input logic [1:0]        cnt_q,
  input logic              rd_pend_q,
  input logic [LANES-1:0]  lane_we,
  input logic              cpu_ign,
  input logic              ctl_desel,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  // R2
  cpu_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !cs_n) |-> (lane_we == '0));

  // R2
  cpu_read_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !cs_n) |=> rd_pend_q);

  // R3
  cpu_ign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ign |=> (sel_q == $past(sel_q)) && (cnt_q == $past(cnt_q)) && !rd_pend_q);

  // R3
  cpu_ign_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ign |-> (lane_we == '0));

  // R5
  ctl_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_desel |=> !sel_q);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && cpu_stb_n && ctl_stb_n) |-> (lane_we == '0));

  // R5
  idle_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && cpu_stb_n && ctl_stb_n) |=> !rd_pend_q && !sel_q && $stable(cnt_q));

  // R6
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && cpu_stb_n && ctl_stb_n && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R9
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_we & bwe_n) == '0));

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_valid && (rd_data == '0)));

  // R10
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && rd_pend_q) |-> rd_valid);

endmodule

bind burst_cache_sram burst_cache_chk #(.LANES(LANES), .DATA_W(LANES*LANE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_stb_n (cpu_stb_n),
  .ctl_stb_n (ctl_stb_n),
  .cs_n      (cs_n),
  .adv_n     (adv_n),
  .oe_n      (oe_n),
  .bwe_n     (bwe_n),
  .sel_q     (sel_q),
  .cnt_q     (cnt_q),
  .rd_pend_q (rd_pend_q),
  .lane_we   (lane_we),
  .cpu_ign   (cpu_ign),
  .ctl_desel (ctl_desel),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/burst_cache_sram_tb.sv
module burst_cache_sram_tb_top;

  localparam int AW = 8;
  localparam int LN = 8;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cpu_stb_n, ctl_stb_n, adv_n, cs_n, order_sel, oe_n;
  logic [LN-1:0] bwe_n;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_valid;

  logic [DW-1:0] model [1 << AW];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_cache_sram dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .cs_n(cs_n), .bwe_n(bwe_n),
    .order_sel(order_sel), .oe_n(oe_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic cpu, input logic ctl, input logic cs,
                       input logic adv, input logic [LN-1:0] we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_stb_n = cpu; ctl_stb_n = ctl; cs_n = cs; adv_n = adv;
    bwe_n = we; addr = a; wr_data = d;
    tick();
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] we);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < LN; i++)
      if (!we[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int k);
    return {8{8'(k * 37 + 5)}} ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction

  task automatic expect_read(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rd_valid !== 1'b1 || rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_valid=%b rd_data=%h, expected rd_valid=1 rd_data=%h",
               req, rd_valid, rd_data, exp);
    end
  endtask

  task automatic expect_none(input string req);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL %s: rd_valid=%b rd_data=%h, expected rd_valid=0 rd_data=0",
               req, rd_valid, rd_data);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // R11: reset state and deselected after reset
  task automatic t_reset();
    rst_n = 1'b0;
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1; cs_n = 1; bwe_n = '1;
    order_sel = 1; oe_n = 0; addr = '0; wr_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_none("R11 reset output");
    drive(1, 1, 0, 0, '1, 8'h00, '0);
    expect_none("R11 deselected after reset, advance ignored");
  endtask

  // R4 R6 R7 R9: controller-started interleaved write burst from 0x11
  task automatic t_write_burst();
    order_sel = 1;
    drive(1, 0, 0, 1, 8'h00, 8'h11, pat(0)); model[8'h11] = pat(0);
    expect_none("R4 write start gives no read");
    drive(1, 1, 0, 0, 8'h00, 8'hEE, pat(1)); model[8'h10] = pat(1);
    expect_none("R6 write continuation gives no read");
    drive(1, 1, 0, 0, 8'h00, 8'hEE, pat(2)); model[8'h13] = pat(2);
    drive(1, 1, 0, 0, 8'h00, 8'hEE, pat(3)); model[8'h12] = pat(3);
    expect_none("R6 write continuation gives no read");
  endtask

  // R1 R2 R7: processor-started interleaved read from 0x11
  task automatic t_read_interleaved();
    order_sel = 1;
    drive(0, 1, 0, 1, 8'h00, 8'h11, '0);
    expect_read("R1/R2 first read ignores write enables", model[8'h11]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R7 step1 addr 0x10", model[8'h10]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R7 step2 addr 0x13", model[8'h13]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R7 step3 addr 0x12", model[8'h12]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R7 wrap addr 0x11", model[8'h11]);
    drive(1, 1, 0, 1, '1, 8'h00, '0); expect_read("R6 hold without advance", model[8'h11]);
  endtask

  // R8: linear read from 0x11
  task automatic t_read_linear();
    order_sel = 0;
    drive(0, 1, 0, 1, '1, 8'h11, '0); expect_read("R8 start 0x11", model[8'h11]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R8 linear 0x12", model[8'h12]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R8 linear 0x13", model[8'h13]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R8 linear wrap 0x10", model[8'h10]);
    order_sel = 1;
  endtask

  // R9: byte-lane masked write, read back through controller strobe (R4)
  task automatic t_byte_lanes();
    drive(1, 0, 0, 1, 8'h00, 8'h20, pat(10)); model[8'h20] = pat(10);
    drive(1, 0, 0, 1, 8'hA5, 8'h20, pat(11));
    model[8'h20] = merge(model[8'h20], pat(11), 8'hA5);
    drive(1, 0, 0, 1, 8'hFF, 8'h20, '0);
    expect_read("R9/R4 lanes 1,3,4,6 written, others kept", model[8'h20]);
  endtask

  // R2: both strobes, processor wins; write enables act on next edge
  task automatic t_both_strobes();
    drive(1, 0, 0, 1, 8'h00, 8'h30, pat(20)); model[8'h30] = pat(20);
    drive(0, 0, 0, 1, 8'h00, 8'h30, pat(21));
    expect_read("R2 both strobes read old word", model[8'h30]);
    drive(1, 1, 0, 1, 8'h00, 8'h00, pat(21)); model[8'h30] = pat(21);
    expect_none("R2 next-edge write gives no read");
    drive(0, 1, 0, 1, '1, 8'h30, '0);
    expect_read("R2 next-edge write landed", model[8'h30]);
  endtask

  // R3: processor strobe with chip select high is ignored
  task automatic t_cpu_ignored();
    drive(1, 0, 0, 1, 8'h00, 8'h40, pat(30)); model[8'h40] = pat(30);
    drive(1, 1, 0, 0, 8'h00, 8'h00, pat(31)); model[8'h41] = pat(31);
    drive(1, 1, 0, 0, 8'h00, 8'h00, pat(32)); model[8'h42] = pat(32);
    drive(1, 1, 0, 0, 8'h00, 8'h00, pat(33)); model[8'h43] = pat(33);
    drive(0, 1, 0, 1, '1, 8'h40, '0);
    expect_read("R3 setup read 0x40", model[8'h40]);
    drive(0, 1, 1, 0, 8'h00, 8'h42, 64'hDEAD_BEEF_DEAD_BEEF);
    expect_none("R3 ignored cycle gives no read");
    drive(1, 1, 0, 0, '1, 8'h00, '0);
    expect_read("R3 burst kept, count unchanged, 0x41", model[8'h41]);
    drive(1, 1, 0, 0, '1, 8'h00, '0);
    expect_read("R3 no write at 0x42", model[8'h42]);
  endtask

  // R5: controller deselect; advance and writes ignored while deselected
  task automatic t_deselect();
    drive(0, 1, 0, 1, '1, 8'h40, '0);
    expect_read("R5 setup read 0x40", model[8'h40]);
    drive(1, 0, 1, 1, '1, 8'h00, '0);
    expect_none("R5 deselect cycle");
    drive(1, 1, 0, 0, 8'h00, 8'h00, 64'h1111_2222_3333_4444);
    expect_none("R5 advance+write ignored while deselected");
    drive(1, 1, 0, 1, 8'h00, 8'h00, 64'h5555_6666_7777_8888);
    expect_none("R5 write ignored while deselected");
    drive(0, 1, 1, 1, '1, 8'h00, '0);
    expect_none("R3/R5 processor strobe with cs high stays deselected");
    drive(1, 1, 0, 0, '1, 8'h00, '0);
    expect_none("R5 still deselected");
    drive(0, 1, 0, 1, '1, 8'h40, '0);
    expect_read("R5 0x40 unchanged", model[8'h40]);
    drive(1, 1, 0, 0, '1, 8'h00, '0);
    expect_read("R5 0x41 unchanged", model[8'h41]);
  endtask

  // R10: asynchronous output enable
  task automatic t_oe();
    drive(0, 1, 0, 1, '1, 8'h10, '0);
    expect_read("R10 baseline read", model[8'h10]);
    oe_n = 1'b1; #1;
    expect_none("R10 oe high releases bus without a clock");
    oe_n = 1'b0; #1;
    expect_read("R10 oe low restores pending word", model[8'h10]);
  endtask

  // R8: order switched mid-burst
  task automatic t_order_switch();
    order_sel = 1;
    drive(0, 1, 0, 1, '1, 8'h43, '0); expect_read("R8 start 0x43", model[8'h43]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R7 interleaved 0x42", model[8'h42]);
    order_sel = 0;
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R8 switched to linear 0x41", model[8'h41]);
    drive(1, 1, 0, 0, '1, 8'h00, '0); expect_read("R8 linear 0x42", model[8'h42]);
    order_sel = 1;
  endtask

  initial begin
    t_reset();
    t_write_burst();
    t_read_interleaved();
    t_read_linear();
    t_byte_lanes();
    t_both_strobes();
    t_cpu_ignored();
    t_deselect();
    t_oe();
    t_order_switch();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, expected completion");
      summary();
      $finish;
    end
  end

endmodule